// File: doc/BRIEF.md
# SDR SDRAM Command Decoder with Bank and DQM Tracking

This block sits beside a single-data-rate SDRAM interface with four banks and a 16-bit data path, and watches the control pins at every rising clock edge. It sorts each sampled cycle into one command and presents that command on a registered code output one cycle later, together with the fields the command carries: bank, row, column, the per-access auto-precharge request and the all-banks precharge flag. Fields that a command does not carry read as zero.

Alongside the decode it keeps a per-bank table of which row is open. The table is set by row activation, cleared by single or all-bank precharge, and cleared after an access with auto-precharge once its burst has run out. Activating a bank that is already open, accessing a closed bank, or refreshing with any bank open raises a one-cycle protocol-error pulse. The last mode-register op-code is held for inspection.

The DQM pin becomes two enable strobes: a write-data enable that follows DQM in the same cycle, and a read output enable that follows DQM with a fixed two-edge latency.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: When chip-select is high at an edge, the cycle is a command inhibit: after that edge the command code is 0, the bank, row, column, auto-precharge and all-banks outputs are 0, and no bank opens or closes because of it, whatever the other pins carry.
- R2: With chip-select low, the pins (RAS#, CAS#, WE#) decode as H,H,H to NOP (1), L,H,H to ACTIVE (2), H,L,H to READ (3), H,L,L to WRITE (4), H,H,L to BURST TERMINATE (5), L,H,L to PRECHARGE (6), L,L,H to AUTO REFRESH (7) or SELF REFRESH (8), L,L,L to LOAD MODE (9); the code for an edge appears on the command output right after that edge.
- R3: ACTIVE reports the bank from BA[1:0] and the row from A[11:0], marks that bank open and stores the row in the bank's slot of the open-rows output (bank b at bits 12*b+11 down to 12*b).
- R4: READ and WRITE report the bank, the column from A[7:0] and an auto-precharge flag equal to A10; a READ or WRITE to a closed bank raises the error pulse.
- R5: PRECHARGE with A10 low closes only the bank on BA[1:0]; with A10 high it closes all four banks, reports the all-banks flag and ignores BA.
- R6: The refresh command is AUTO REFRESH when CKE is high and SELF REFRESH when CKE is low; its address and bank inputs are ignored (fields read 0), and it raises the error pulse if any bank is open.
- R7: LOAD MODE captures A[11:0] into the mode output, which holds until the next LOAD MODE.
- R8: A READ or WRITE with auto-precharge at edge N leaves the bank open through edge N+3 and closes it at edge N+4 (burst length 4).
- R9: ACTIVE to a bank that is already open raises the error pulse and leaves the stored row unchanged.
- R10: The write-data enable is the inverse of DQM in the same cycle, with no register on the path.
- R11: The read output enable present at edge N+2 equals the inverse of DQM sampled at edge N.
- R12: A synchronous active-low reset closes all banks, clears stored rows, mode, error pulse and the read-enable pipeline, and sets the command code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, rising edge samples pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cke_i | input | 1 | Clock-enable pin |
| cs_n_i | input | 1 | Chip-select pin, active low |
| ras_n_i | input | 1 | Row strobe pin, active low |
| cas_n_i | input | 1 | Column strobe pin, active low |
| we_n_i | input | 1 | Write-enable pin, active low |
| dqm_i | input | 1 | Data mask pin |
| ba_i | input | 2 | Bank address pins |
| addr_i | input | 12 | Address pins |
| cmd_o | output | 4 | Registered command code |
| bank_o | output | 2 | Bank carried by the command |
| row_o | output | 12 | Row carried by ACTIVE |
| col_o | output | 8 | Column carried by READ/WRITE |
| auto_pre_o | output | 1 | Auto-precharge request of READ/WRITE |
| pre_all_o | output | 1 | PRECHARGE targets all banks |
| bank_open_o | output | 4 | One bit per bank, high while a row is open |
| open_rows_o | output | 48 | Open row of each bank, 12 bits per bank |
| mode_o | output | 12 | Last captured mode op-code |
| proto_err_o | output | 1 | One-cycle protocol-error pulse |
| wr_en_o | output | 1 | Write-data enable, same cycle as DQM |
| rd_oe_o | output | 1 | Read output enable, delayed from DQM |

## Verification
The bench aims at the A10 rules: a decoder that mixed them up would close every bank on a single precharge, or report a column with A10 folded in, or miss the auto-precharge flag. It presents a cycle with chip-select high but the other pins forming a precharge-all, where a decoder that looked past chip-select would close an open bank. It counts edges after an auto-precharge read to catch a close that comes one edge early or late, and it steps DQM through an irregular pattern so that a read pipeline one stage short or long, or a write enable that was registered, shows a mismatch.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

   typedef enum logic [3:0] {
      CMD_INHIBIT = 4'd0,
      CMD_NOP     = 4'd1,
      CMD_ACTIVE  = 4'd2,
      CMD_READ    = 4'd3,
      CMD_WRITE   = 4'd4,
      CMD_BTERM   = 4'd5,
      CMD_PRECH   = 4'd6,
      CMD_AREF    = 4'd7,
      CMD_SREF    = 4'd8,
      CMD_LMR     = 4'd9
   } cmd_e;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_mon_pkg::*;
#(
   parameter int BA_W   = 2,
   parameter int ROW_W  = 12,
   parameter int COL_W  = 8,
   parameter int AP_BIT = 10
) (
   input  logic             cke_i,
   input  logic             cs_n_i,
   input  logic             ras_n_i,
   input  logic             cas_n_i,
   input  logic             we_n_i,
   input  logic [BA_W-1:0]  ba_i,
   input  logic [ROW_W-1:0] addr_i,
   output cmd_e             cmd_o,
   output logic [BA_W-1:0]  bank_o,
   output logic [ROW_W-1:0] row_o,
   output logic [COL_W-1:0] col_o,
   output logic             auto_pre_o,
   output logic             pre_all_o
);

   logic is_access;
   logic is_single_pre;

   always_comb begin
      if (cs_n_i) begin
         cmd_o = CMD_INHIBIT;
      end else begin
         case ({ras_n_i, cas_n_i, we_n_i})
            3'b111:  cmd_o = CMD_NOP;
            3'b011:  cmd_o = CMD_ACTIVE;
            3'b101:  cmd_o = CMD_READ;
            3'b100:  cmd_o = CMD_WRITE;
            3'b110:  cmd_o = CMD_BTERM;
            3'b010:  cmd_o = CMD_PRECH;
            3'b001:  cmd_o = cke_i ? CMD_AREF : CMD_SREF;
            default: cmd_o = CMD_LMR;
         endcase
      end
   end

   assign is_access     = (cmd_o == CMD_READ) || (cmd_o == CMD_WRITE);
   assign is_single_pre = (cmd_o == CMD_PRECH) && !addr_i[AP_BIT];

   assign bank_o     = (is_access || is_single_pre || cmd_o == CMD_ACTIVE) ? ba_i : '0;
   assign row_o      = (cmd_o == CMD_ACTIVE) ? addr_i : '0;
   assign col_o      = is_access ? addr_i[COL_W-1:0] : '0;
   assign auto_pre_o = is_access && addr_i[AP_BIT];
   assign pre_all_o  = (cmd_o == CMD_PRECH) && addr_i[AP_BIT];

endmodule

// File: rtl/sdram_bank_table.sv
module sdram_bank_table
   import sdram_mon_pkg::*;
#(
   parameter int BA_W      = 2,
   parameter int ROW_W     = 12,
   parameter int BURST_LEN = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  cmd_e                          cmd_i,
   input  logic [BA_W-1:0]               bank_i,
   input  logic [ROW_W-1:0]              row_i,
   input  logic                          auto_pre_i,
   input  logic                          pre_all_i,
   output logic [(1<<BA_W)-1:0]          open_o,
   output logic [(1<<BA_W)*ROW_W-1:0]    rows_o,
   output logic                          err_o
);

   localparam int NBANK = 1 << BA_W;
   localparam int CNT_W = $clog2(BURST_LEN + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BURST_LEN);

   logic is_access;
   logic is_refresh;
   logic err_d;
   logic err_q;

   assign is_access  = (cmd_i == CMD_READ) || (cmd_i == CMD_WRITE);
   assign is_refresh = (cmd_i == CMD_AREF) || (cmd_i == CMD_SREF);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic             open_r;
      logic [ROW_W-1:0] row_r;
      logic [CNT_W-1:0] cnt_r;
      logic             hit;

      assign hit = (bank_i == BA_W'(b));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_r <= 1'b0;
            row_r  <= '0;
            cnt_r  <= '0;
         end else begin
            if (cnt_r != '0) begin
               cnt_r <= cnt_r - 1'b1;
               if (cnt_r == CNT_W'(1)) open_r <= 1'b0;
            end
            case (cmd_i)
               CMD_ACTIVE: begin
                  if (hit && !open_r) begin
                     open_r <= 1'b1;
                     row_r  <= row_i;
                  end
               end
               CMD_READ, CMD_WRITE: begin
                  if (hit && open_r && auto_pre_i) begin
                     cnt_r  <= CNT_LOAD;
                     open_r <= 1'b1;
                  end
               end
               CMD_PRECH: begin
                  if (pre_all_i || hit) begin
                     open_r <= 1'b0;
                     cnt_r  <= '0;
                  end
               end
               default: ;
            endcase
         end
      end

      assign open_o[b] = open_r;
      assign rows_o[b*ROW_W +: ROW_W] = row_r;
   end

   always_comb begin
      err_d = 1'b0;
      if (cmd_i == CMD_ACTIVE && open_o[bank_i]) err_d = 1'b1;
      if (is_access && !open_o[bank_i])          err_d = 1'b1;
      if (is_refresh && (|open_o))               err_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= err_d;
   end

   assign err_o = err_q;

   // R9
   act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_ACTIVE && open_o[bank_i]) |=> (err_o && $stable(rows_o)));

   // R5
   prech_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_PRECH && pre_all_i) |=> (open_o == '0));

   // R6
   refresh_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_refresh && (|open_o)) |=> err_o);

   // R3
   act_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_ACTIVE && !open_o[bank_i]) |=> open_o[$past(bank_i)]);

endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
   parameter int RD_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dqm_i,
   output logic wr_en_o,
   output logic rd_oe_o
);

   localparam int SINCE_W = $clog2(RD_LAT + 1);

   assign wr_en_o = !dqm_i;

   if (RD_LAT == 1) begin : g_single
      logic en_q;
      always_ff @(posedge clk) begin
         if (!rst_n) en_q <= 1'b0;
         else        en_q <= !dqm_i;
      end
      assign rd_oe_o = en_q;
   end else begin : g_shift
      logic [RD_LAT-1:0] en_q;
      always_ff @(posedge clk) begin
         if (!rst_n) en_q <= '0;
         else        en_q <= {en_q[RD_LAT-2:0], !dqm_i};
      end
      assign rd_oe_o = en_q[RD_LAT-1];
   end

   logic [SINCE_W-1:0] since_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                          since_q <= '0;
      else if (since_q != SINCE_W'(RD_LAT)) since_q <= since_q + 1'b1;
   end

   // R11
   rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q == SINCE_W'(RD_LAT)) |-> (rd_oe_o == !$past(dqm_i, RD_LAT)));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
   import sdram_mon_pkg::*;
#(
   parameter int BA_W      = 2,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 8,
   parameter int AP_BIT    = 10,
   parameter int BURST_LEN = 4,
   parameter int RD_LAT    = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           cke_i,
   input  logic                           cs_n_i,
   input  logic                           ras_n_i,
   input  logic                           cas_n_i,
   input  logic                           we_n_i,
   input  logic                           dqm_i,
   input  logic [BA_W-1:0]                ba_i,
   input  logic [ROW_W-1:0]               addr_i,
   output logic [3:0]                     cmd_o,
   output logic [BA_W-1:0]                bank_o,
   output logic [ROW_W-1:0]               row_o,
   output logic [COL_W-1:0]               col_o,
   output logic                           auto_pre_o,
   output logic                           pre_all_o,
   output logic [(1<<BA_W)-1:0]           bank_open_o,
   output logic [(1<<BA_W)*ROW_W-1:0]     open_rows_o,
   output logic [ROW_W-1:0]               mode_o,
   output logic                           proto_err_o,
   output logic                           wr_en_o,
   output logic                           rd_oe_o
);

   if (BA_W < 1 || COL_W < 1 || COL_W > AP_BIT || AP_BIT >= ROW_W) begin : g_bad_fields
      $error("sdram_cmd_monitor: field widths do not fit the address bus");
   end
   if (BURST_LEN < 1 || RD_LAT < 1 || RD_LAT > 4) begin : g_bad_timing
      $error("sdram_cmd_monitor: BURST_LEN or RD_LAT out of range");
   end

   cmd_e             cmd_d;
   logic [BA_W-1:0]  bank_d;
   logic [ROW_W-1:0] row_d;
   logic [COL_W-1:0] col_d;
   logic             ap_d;
   logic             all_d;

   cmd_e             cmd_q;
   logic [BA_W-1:0]  bank_q;
   logic [ROW_W-1:0] row_q;
   logic [COL_W-1:0] col_q;
   logic             ap_q;
   logic             all_q;
   logic [ROW_W-1:0] mode_q;

   sdram_cmd_decode #(
      .BA_W   (BA_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .AP_BIT (AP_BIT)
   ) dec_i (
      .cke_i      (cke_i),
      .cs_n_i     (cs_n_i),
      .ras_n_i    (ras_n_i),
      .cas_n_i    (cas_n_i),
      .we_n_i     (we_n_i),
      .ba_i       (ba_i),
      .addr_i     (addr_i),
      .cmd_o      (cmd_d),
      .bank_o     (bank_d),
      .row_o      (row_d),
      .col_o      (col_d),
      .auto_pre_o (ap_d),
      .pre_all_o  (all_d)
   );

   sdram_bank_table #(
      .BA_W      (BA_W),
      .ROW_W     (ROW_W),
      .BURST_LEN (BURST_LEN)
   ) banks_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_i      (cmd_d),
      .bank_i     (bank_d),
      .row_i      (row_d),
      .auto_pre_i (ap_d),
      .pre_all_i  (all_d),
      .open_o     (bank_open_o),
      .rows_o     (open_rows_o),
      .err_o      (proto_err_o)
   );

   sdram_dqm_pipe #(
      .RD_LAT (RD_LAT)
   ) dqm_i_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .dqm_i   (dqm_i),
      .wr_en_o (wr_en_o),
      .rd_oe_o (rd_oe_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= CMD_INHIBIT;
         bank_q <= '0;
         row_q  <= '0;
         col_q  <= '0;
         ap_q   <= 1'b0;
         all_q  <= 1'b0;
         mode_q <= '0;
      end else begin
         cmd_q  <= cmd_d;
         bank_q <= bank_d;
         row_q  <= row_d;
         col_q  <= col_d;
         ap_q   <= ap_d;
         all_q  <= all_d;
         if (cmd_d == CMD_LMR) mode_q <= addr_i;
      end
   end

   assign cmd_o      = cmd_q;
   assign bank_o     = bank_q;
   assign row_o      = row_q;
   assign col_o      = col_q;
   assign auto_pre_o = ap_q;
   assign pre_all_o  = all_q;
   assign mode_o     = mode_q;

   // R1
   cs_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_i |=> (cmd_o == 4'd0 && bank_o == '0 && row_o == '0 && col_o == '0
                  && !auto_pre_o && !pre_all_o));

   // R7
   lmr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_i && !ras_n_i && !cas_n_i && !we_n_i) |=> (mode_o == $past(addr_i)));

endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cke, cs_n, ras_n, cas_n, we_n, dqm;
   logic [1:0]  ba;
   logic [11:0] addr;
   logic [3:0]  cmd;
   logic [1:0]  bank;
   logic [11:0] row;
   logic [7:0]  col;
   logic        ap, pall, err, wr_en, rd_oe;
   logic [3:0]  bopen;
   logic [47:0] orows;
   logic [11:0] mode;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   sdram_cmd_monitor dut_i (
      .clk (clk), .rst_n (rst_n), .cke_i (cke), .cs_n_i (cs_n), .ras_n_i (ras_n),
      .cas_n_i (cas_n), .we_n_i (we_n), .dqm_i (dqm), .ba_i (ba), .addr_i (addr),
      .cmd_o (cmd), .bank_o (bank), .row_o (row), .col_o (col), .auto_pre_o (ap),
      .pre_all_o (pall), .bank_open_o (bopen), .open_rows_o (orows), .mode_o (mode),
      .proto_err_o (err), .wr_en_o (wr_en), .rd_oe_o (rd_oe)
   );

   // {cs,ras,cas,we}, cke, ba, addr, expected cmd, expected error, expected open banks
   localparam int NV = 14;
   localparam logic [27:0] VEC [NV] = '{
      {4'b0111, 1'b1, 2'd0, 12'h000, 4'd1, 1'b0, 4'b0000},  // R2 NOP
      {4'b1000, 1'b1, 2'd3, 12'hFFF, 4'd0, 1'b0, 4'b0000},  // R1 inhibit
      {4'b0011, 1'b1, 2'd1, 12'h123, 4'd2, 1'b0, 4'b0010},  // R3 activate b1
      {4'b0011, 1'b1, 2'd1, 12'h456, 4'd2, 1'b1, 4'b0010},  // R9 reactivate
      {4'b0101, 1'b1, 2'd2, 12'h010, 4'd3, 1'b1, 4'b0010},  // R4 read closed
      {4'b0100, 1'b1, 2'd1, 12'h020, 4'd4, 1'b0, 4'b0010},  // R4 write open
      {4'b0110, 1'b1, 2'd0, 12'h000, 4'd5, 1'b0, 4'b0010},  // R2 burst stop
      {4'b0011, 1'b1, 2'd3, 12'h007, 4'd2, 1'b0, 4'b1010},  // R3 activate b3
      {4'b0001, 1'b1, 2'd0, 12'h000, 4'd7, 1'b1, 4'b1010},  // R6 refresh open
      {4'b0010, 1'b1, 2'd1, 12'h000, 4'd6, 1'b0, 4'b1000},  // R5 single pre
      {4'b0010, 1'b1, 2'd0, 12'h400, 4'd6, 1'b0, 4'b0000},  // R5 all pre
      {4'b0001, 1'b0, 2'd0, 12'h000, 4'd8, 1'b0, 4'b0000},  // R6 self refresh
      {4'b0001, 1'b1, 2'd0, 12'h000, 4'd7, 1'b0, 4'b0000},  // R6 auto refresh
      {4'b0000, 1'b1, 2'd0, 12'h033, 4'd9, 1'b0, 4'b0000}   // R7 load mode
   };

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] pins, input logic k, input logic [1:0] b,
                        input logic [11:0] a);
      {cs_n, ras_n, cas_n, we_n} = pins;
      cke  = k;
      ba   = b;
      addr = a;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [5:0] pat;
      rst_n = 1'b0;
      dqm   = 1'b1;
      {cs_n, ras_n, cas_n, we_n} = 4'b0111;
      cke = 1'b1; ba = '0; addr = '0;
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 cmd", 64'(cmd), 64'd0);
      check("R12 open", 64'(bopen), 64'd0);
      check("R12 mode", 64'(mode), 64'd0);
      check("R12 err", 64'(err), 64'd0);
      check("R12 rd_oe", 64'(rd_oe), 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][27:24], VEC[i][23], VEC[i][22:21], VEC[i][20:9]);
         check("R2 cmd", 64'(cmd), 64'(VEC[i][8:5]));
         check("R4 err", 64'(err), 64'(VEC[i][4]));
         check("R3 open", 64'(bopen), 64'(VEC[i][3:0]));
      end
      check("R7 mode", 64'(mode), 64'h033);
      drive(4'b0111, 1'b1, 2'd0, 12'hABC);
      check("R7 mode held", 64'(mode), 64'h033);

      // R3 fields
      drive(4'b0011, 1'b1, 2'd2, 12'hABC);
      check("R3 bank", 64'(bank), 64'd2);
      check("R3 row", 64'(row), 64'hABC);
      check("R3 row slot", 64'(orows[35:24]), 64'hABC);
      // R9 row kept
      drive(4'b0011, 1'b1, 2'd2, 12'h111);
      check("R9 err", 64'(err), 64'd1);
      check("R9 row kept", 64'(orows[35:24]), 64'hABC);
      // R4 read with auto-precharge
      drive(4'b0101, 1'b1, 2'd2, 12'h4C5);
      check("R4 cmd", 64'(cmd), 64'd3);
      check("R4 col", 64'(col), 64'hC5);
      check("R4 ap", 64'(ap), 64'd1);
      check("R4 bank", 64'(bank), 64'd2);
      check("R4 err", 64'(err), 64'd0);
      // R8 close at fourth edge after the access
      for (int i = 1; i <= 3; i++) begin
         drive(4'b0111, 1'b1, 2'd0, 12'h000);
         check("R8 still open", 64'(bopen[2]), 64'd1);
      end
      drive(4'b0111, 1'b1, 2'd0, 12'h000);
      check("R8 closed", 64'(bopen[2]), 64'd0);
      drive(4'b0101, 1'b1, 2'd2, 12'h000);
      check("R4 closed err", 64'(err), 64'd1);

      // R4 write without auto-precharge
      drive(4'b0011, 1'b1, 2'd0, 12'h005);
      drive(4'b0100, 1'b1, 2'd0, 12'h0FF);
      check("R4 wr col", 64'(col), 64'hFF);
      check("R4 wr ap", 64'(ap), 64'd0);
      // R1 inhibit shaped like precharge-all
      drive(4'b1010, 1'b1, 2'd0, 12'h400);
      check("R1 cmd", 64'(cmd), 64'd0);
      check("R1 pre_all", 64'(pall), 64'd0);
      check("R1 bank kept", 64'(bopen[0]), 64'd1);
      // R6 address ignored, error with open bank
      drive(4'b0001, 1'b1, 2'd3, 12'hFFF);
      check("R6 cmd", 64'(cmd), 64'd7);
      check("R6 err", 64'(err), 64'd1);
      check("R6 fields", 64'({bank, row, col}), 64'd0);
      // R5 all-bank precharge ignores BA
      drive(4'b0010, 1'b1, 2'd3, 12'h400);
      check("R5 pre_all", 64'(pall), 64'd1);
      check("R5 all closed", 64'(bopen), 64'd0);

      // R10 write enable same cycle
      dqm = 1'b1; #1;
      check("R10 masked", 64'(wr_en), 64'd0);
      dqm = 1'b0; #1;
      check("R10 enabled", 64'(wr_en), 64'd1);
      @(negedge clk);
      // R11 read enable latency
      pat = 6'b101101;
      for (int i = 0; i < 6; i++) begin
         dqm = pat[i];
         @(negedge clk);
         if (i >= 1) check("R11 rd_oe", 64'(rd_oe), 64'(!pat[i-1]));
      end

      // R12 mid-run reset
      dqm = 1'b0;
      drive(4'b0011, 1'b1, 2'd1, 12'h0AA);
      drive(4'b0111, 1'b1, 2'd0, 12'h000);
      rst_n = 1'b0;
      @(negedge clk);
      check("R12 open", 64'(bopen), 64'd0);
      check("R12 rows", 64'(orows), 64'd0);
      check("R12 mode", 64'(mode), 64'd0);
      check("R12 rd_oe", 64'(rd_oe), 64'd0);
      check("R12 cmd", 64'(cmd), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule